// File: doc/BRIEF.md
# Delay-Degradation Failover Monitor

This block sits after a small logic region that exists in two copies, a primary and a spare. Each copy has a path-delay sensing flip-flop that raises a late-arrival warning bit in any cycle where the sensed path delay falls inside a narrow band just below the clock period. A slowly degrading region shows this as warnings that keep coming cycle after cycle. A transient upset shows only an isolated warning. The monitor filters the warning of the copy currently in use over consecutive cycles. When the run is long enough, it predicts a failure and moves the region's output to the spare before any wrong result is produced.

The selection is sticky. Once the spare is in service, the spare's own warning feeds the same filter. If the spare then degrades, a sticky fatal flag is raised, because at that point both copies are considered failed. A saturating counter reports how many monitored warning cycles have been seen. A one-cycle pulse marks each predicted failure.

Top module: `dly_failover_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, using_spare, fatal and predicted_fail are 0, event_count is 0, and out_data equals primary_data.
- R2: When primary_warn is 1 on RUN_LEN consecutive rising edges, using_spare becomes 1 right after the edge that samples the last of them.
- R3: A run of primary warnings shorter than RUN_LEN, followed by one edge with no warning, restarts the run count from zero, so no failover occurs.
- R4: using_spare stays 1 until reset; primary_warn has no effect once the spare is in service.
- R5: Before failover, spare_warn is ignored: it does not change event_count, using_spare or fatal.
- R6: After failover, spare_warn on RUN_LEN consecutive edges sets fatal, which stays 1 until reset. Once fatal is set, no warning bit is monitored any more.
- R7: predicted_fail is 1 for exactly one cycle after each filter trip (the failover trip and the fatal trip) and is 0 otherwise.
- R8: event_count increments by one on every edge where the monitored warning is 1 (primary before failover, spare after failover, none after fatal). It saturates at 2^CNT_W-1.
- R9: out_data equals spare_data when using_spare is 1 and primary_data otherwise; the source changes only at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| primary_data | input | DATA_W | Result of the primary copy |
| spare_data | input | DATA_W | Result of the spare copy |
| primary_warn | input | 1 | Late-arrival warning of the primary copy |
| spare_warn | input | 1 | Late-arrival warning of the spare copy |
| out_data | output | DATA_W | Selected result |
| using_spare | output | 1 | Spare copy in service (sticky) |
| predicted_fail | output | 1 | One-cycle pulse after a filter trip |
| fatal | output | 1 | Both copies failed (sticky) |
| event_count | output | CNT_W | Saturating count of monitored warning cycles |

## Verification
Spare-only warnings before failover show whether the unused copy's bit leaks into the filter or the counter. Repeated runs one cycle short of the threshold, each broken by a clear cycle, tell a filter that really needs consecutive warnings from one that just accumulates them. Exact-length runs on the primary and then on the spare check where each trip lands, to the edge, and that primary warnings after failover and any warning after the fatal trip change nothing. A long train of isolated warnings after a second reset drives the counter into saturation without tripping the filter.

// File: rtl/dly_failover_mon.sv
module dly_failover_mon #(
  parameter int DATA_W  = 16,
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] primary_data,
  input  logic [DATA_W-1:0] spare_data,
  input  logic              primary_warn,
  input  logic              spare_warn,
  output logic [DATA_W-1:0] out_data,
  output logic              using_spare,
  output logic              predicted_fail,
  output logic              fatal,
  output logic [CNT_W-1:0]  event_count
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [RUN_W-1:0] run_cnt;
  logic             watched;
  logic             trip;

  assign watched  = !fatal && (using_spare ? spare_warn : primary_warn);
  assign trip     = watched && (run_cnt == RUN_LAST);
  assign out_data = using_spare ? spare_data : primary_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt        <= '0;
      using_spare    <= 1'b0;
      fatal          <= 1'b0;
      predicted_fail <= 1'b0;
      event_count    <= '0;
    end else begin
      predicted_fail <= trip;
      if (!watched || trip) run_cnt <= '0;
      else                  run_cnt <= run_cnt + 1'b1;
      if (trip) begin
        if (using_spare) fatal       <= 1'b1;
        else             using_spare <= 1'b1;
      end
      if (watched && event_count != CNT_MAX) event_count <= event_count + 1'b1;
    end
  end

  assert_spare_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    using_spare |=> using_spare);
  assert_failover_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(using_spare) |-> $past(primary_warn));
  assert_fatal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  assert_fatal_needs_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> using_spare);
  assert_pulse_on_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    predicted_fail |-> ($rose(using_spare) || $rose(fatal)));
  assert_spare_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!using_spare && !primary_warn) |=> $stable(event_count));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (event_count == CNT_MAX) |=> (event_count == CNT_MAX));
endmodule

// File: tb/tb_dly_failover_mon.sv
module tb_dly_failover_mon;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int RUN = 4;
  localparam int CW  = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [DW-1:0] primary_data = '0, spare_data = '0;
  logic primary_warn = 0, spare_warn = 0;
  logic [DW-1:0] out_data;
  logic using_spare, predicted_fail, fatal;
  logic [CW-1:0] event_count;

  int checks = 0, errors = 0;
  int m_run = 0, m_evt = 0;
  bit m_spare = 0, m_fatal = 0, m_pulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_failover_mon #(.DATA_W(DW), .RUN_LEN(RUN), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .primary_data(primary_data), .spare_data(spare_data),
    .primary_warn(primary_warn), .spare_warn(spare_warn), .out_data(out_data),
    .using_spare(using_spare), .predicted_fail(predicted_fail), .fatal(fatal),
    .event_count(event_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R9 out_data"}, int'(out_data), int'(m_spare ? spare_data : primary_data));
    chk({tag, " R2/R4 using_spare"}, int'(using_spare), int'(m_spare));
    chk({tag, " R7 predicted_fail"}, int'(predicted_fail), int'(m_pulse));
    chk({tag, " R6 fatal"}, int'(fatal), int'(m_fatal));
    chk({tag, " R8 event_count"}, int'(event_count), m_evt);
  endtask

  task automatic step(input bit pw, input bit sw, input string tag);
    bit w;
    primary_warn = pw; spare_warn = sw;
    primary_data = DW'($urandom); spare_data = DW'($urandom);
    @(posedge clk);
    w = m_fatal ? 1'b0 : (m_spare ? sw : pw);
    m_pulse = 0;
    if (w) begin
      if (m_evt < CMAX) m_evt++;
      m_run++;
      if (m_run == RUN) begin
        m_run = 0; m_pulse = 1;
        if (m_spare) m_fatal = 1; else m_spare = 1;
      end
    end else m_run = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; primary_warn = 0; spare_warn = 0;
    repeat (2) @(negedge clk);
    m_run = 0; m_evt = 0; m_spare = 0; m_fatal = 0; m_pulse = 0;
    compare_all("R1 in reset");
    rst_n = 1;
    step(0, 0, "R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 6; i++) step(0, 1, "R5 spare warn ignored");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < RUN - 1; i++) step(1, 0, "R3 short run");
      step(0, 1, "R3 run broken");
    end
    for (int i = 0; i < RUN; i++) step(1, 0, "R2 full run");
    step(1, 0, "R4 primary warn after failover");
    for (int i = 0; i < 4; i++) step(1, 0, "R4 sticky");
    for (int i = 0; i < RUN - 1; i++) step(0, 1, "R6 short spare run");
    step(1, 0, "R6 spare run broken");
    for (int i = 0; i < RUN; i++) step(0, 1, "R6 spare full run");
    for (int i = 0; i < 6; i++) step(1, 1, "R6 after fatal");
    do_reset();
    for (int i = 0; i < CMAX + 5; i++) begin
      step(1, 0, "R8 isolated warn");
      step(0, 0, "R3 isolated gap");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule